// File: doc/BRIEF.md
# Serial Sampling Converter Readout Controller

This block is the host-side master for a 14-bit serial sampling analog-to-digital converter reached over a three-wire link: an active-low chip select, a shift clock and a serial data return. Pulling chip select low starts a conversion. The controller then produces sixteen shift-clock pulses, which it derives from the system clock through a programmable divider. On each rising shift-clock edge it samples the data line.

Each returned frame has a zero pad in front, fourteen data bits with the most significant bit first, and a zero pad behind. The controller removes the pads and presents the 14-bit word with a one-cycle valid strobe. It flags a framing error when a pad bit is not zero.

The converter has one conversion of latency. The word in a frame belongs to the conversion before it, so the first frame after reset, or after `enable` rises, is read but not reported. Between frames chip select is held high for an acquisition gap. A runtime gap setting gives the gap length, and the controller stretches the gap to a fixed minimum so that the converter's acquisition time is always met.

Top module: `sar_link_reader`

## Requirements
- R1: During and right after reset, `csN` is high, `sck` is low and `sampleValid` is low.
- R2: Each frame holds `csN` low for exactly 16 rising edges of `sck`. `sck` idles low and is never high while `csN` is high.
- R3: `sdoIn` is sampled on each rising `sck` edge, and the first sample is the leading pad. The samples at positions 2 to 15 (counting from 1) form `sampleData`, most significant bit first.
- R4: The first frame after reset, and the first frame after `enable` rises, produce no `sampleValid`. Every later frame produces exactly one single-cycle `sampleValid`, which carries that frame's bits.
- R5: `frameErr` is high together with `sampleValid` when the first or the sixteenth sampled bit of that frame was 1. The data bits are still presented.
- R6: Each `sck` half-period lasts `divCfg`+1 system clocks, so rising edges are 2·(`divCfg`+1) clocks apart.
- R7: Between frames, `csN` stays high for max(2·`gapCfg`·(`divCfg`+1), `MIN_ACQ_CYC`) system clocks.
- R8: When `enable` falls during a frame, that frame still completes. `csN` then stays high and no further frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run continuous back-to-back frames while high |
| divCfg | input | DIV_W | Shift-clock half-period in system clocks, minus one |
| gapCfg | input | GAP_W | Requested acquisition gap in shift-clock periods |
| sdoIn | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low chip select, falling edge starts a conversion |
| sck | output | 1 | Shift clock to the converter |
| sampleData | output | DATA_W | Captured conversion word |
| sampleValid | output | 1 | One-cycle strobe marking `sampleData` |
| frameErr | output | 1 | Pad bit of the reported frame was non-zero |

## Verification
The assertions assume that `divCfg` and `gapCfg` do not change while a frame or a gap is in progress. They also assume `sdoIn` only matters during the rising shift edges. The bench keeps to this: it reprograms the configuration only while the controller is idle with `csN` high. Its behavioural converter changes the data line only on falling `sck` edges and on the chip-select fall. The sweep covers every divider value from 0 to 3 and several gap settings, including gaps shorter than the minimum acquisition window, so both the stretched and the programmed gap lengths are exercised.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  // Strobes from control to datapath, each valid for one system clock.
  typedef struct packed {
    logic clear;  // new run starts: next frame is not reported
    logic shift;  // rising shift-clock edge: capture serial bit
    logic done;   // frame ended: publish captured word
  } rdStrb_t;
endpackage

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int DIV_W       = 8,
  parameter int GAP_W       = 8,
  parameter int MIN_ACQ_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divCfg,
  input  logic [GAP_W-1:0] gapCfg,
  output logic             csN,
  output logic             sck,
  output rdStrb_t          strb
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int BIT_W      = $clog2(FRAME_BITS + 1);
  localparam int TGT_W      = GAP_W + DIV_W + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_ACQ} rdState_t;

  rdState_t          state;
  logic [DIV_W-1:0]  phaseCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [TGT_W-1:0]  acqCnt;
  logic              sckR;

  logic              tick;
  logic              lastBit;
  logic [TGT_W-1:0]  halfPer;
  logic [TGT_W-1:0]  gapCyc;
  logic [TGT_W-1:0]  acqTarget;
  logic              acqDone;

  assign tick    = (phaseCnt >= divCfg);
  assign lastBit = (bitCnt == BIT_W'(FRAME_BITS));

  // Acquisition gap: programmed length, raised to the minimum window.
  always_comb begin
    halfPer   = TGT_W'(divCfg) + TGT_W'(1);
    gapCyc    = (TGT_W'(gapCfg) * halfPer) << 1;
    acqTarget = (gapCyc > TGT_W'(MIN_ACQ_CYC)) ? gapCyc : TGT_W'(MIN_ACQ_CYC);
    acqDone   = ((acqCnt + TGT_W'(1)) >= acqTarget);
  end

  always_comb begin
    strb.clear = (state == ST_IDLE) && enable;
    strb.shift = (state == ST_CONV) && tick && !sckR;
    strb.done  = (state == ST_CONV) && tick && sckR && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      csN      <= 1'b1;
      sckR     <= 1'b0;
      phaseCnt <= '0;
      bitCnt   <= '0;
      acqCnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (enable) begin
            state    <= ST_CONV;
            csN      <= 1'b0;
            sckR     <= 1'b0;
            phaseCnt <= '0;
            bitCnt   <= '0;
          end
        end
        ST_CONV: begin
          if (tick) begin
            phaseCnt <= '0;
            if (!sckR) begin
              sckR   <= 1'b1;
              bitCnt <= bitCnt + BIT_W'(1);
            end else begin
              sckR <= 1'b0;
              if (lastBit) begin
                csN    <= 1'b1;
                state  <= ST_ACQ;
                acqCnt <= '0;
              end
            end
          end else begin
            phaseCnt <= phaseCnt + DIV_W'(1);
          end
        end
        ST_ACQ: begin
          if (acqDone) begin
            if (enable) begin
              state    <= ST_CONV;
              csN      <= 1'b0;
              phaseCnt <= '0;
              bitCnt   <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            acqCnt <= acqCnt + TGT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sck = sckR;

  // ---------------- checks ----------------
  logic             sckPrev;
  logic [BIT_W:0]   edgeCnt;
  logic [TGT_W-1:0] csHighCnt;
  logic             framesSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckPrev    <= 1'b0;
      edgeCnt    <= '0;
      csHighCnt  <= '0;
      framesSeen <= 1'b0;
    end else begin
      sckPrev <= sckR;
      if (csN) edgeCnt <= '0;
      else if (sckR && !sckPrev) edgeCnt <= edgeCnt + (BIT_W+1)'(1);
      if (csN) begin
        if (csHighCnt != '1) csHighCnt <= csHighCnt + TGT_W'(1);
      end else begin
        csHighCnt <= '0;
      end
      if (strb.done) framesSeen <= 1'b1;
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck); // R2
  AST_SIXTEEN_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (edgeCnt == (BIT_W+1)'(FRAME_BITS))); // R2
  AST_ACQ_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(csN) && framesSeen) |-> (csHighCnt >= TGT_W'(MIN_ACQ_CYC))); // R7
  AST_CS_RISES_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> csN); // R2
endmodule

// File: rtl/adc_rd_dp.sv
module adc_rd_dp
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdoIn,
  input  rdStrb_t           strb,
  output logic [DATA_W-1:0] sampleData,
  output logic              sampleValid,
  output logic              frameErr
);
  localparam int FRAME_BITS = DATA_W + 2;

  logic [FRAME_BITS-1:0] shiftReg;
  logic                  primed;
  logic                  padBad;

  assign padBad = shiftReg[FRAME_BITS-1] | shiftReg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      primed      <= 1'b0;
      sampleData  <= '0;
      sampleValid <= 1'b0;
      frameErr    <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      frameErr    <= 1'b0;
      if (strb.shift) shiftReg <= {shiftReg[FRAME_BITS-2:0], sdoIn};
      if (strb.clear) primed <= 1'b0;
      if (strb.done) begin
        primed <= 1'b1;
        if (primed) begin
          sampleValid <= 1'b1;
          sampleData  <= shiftReg[FRAME_BITS-2:1];
          frameErr    <= padBad;
        end
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid); // R4
  AST_ERR_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> sampleValid); // R5
  AST_NO_REPORT_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !sampleValid); // R4
endmodule

// File: rtl/sar_link_reader.sv
module sar_link_reader
  import adc_rd_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int DIV_W       = 8,
  parameter int GAP_W       = 8,
  parameter int MIN_ACQ_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divCfg,
  input  logic [GAP_W-1:0]  gapCfg,
  input  logic              sdoIn,
  output logic              csN,
  output logic              sck,
  output logic [DATA_W-1:0] sampleData,
  output logic              sampleValid,
  output logic              frameErr
);
  rdStrb_t strb;

  adc_rd_ctrl #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .GAP_W(GAP_W), .MIN_ACQ_CYC(MIN_ACQ_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .divCfg(divCfg), .gapCfg(gapCfg),
    .csN(csN), .sck(sck), .strb(strb)
  );

  adc_rd_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .sdoIn(sdoIn), .strb(strb),
    .sampleData(sampleData), .sampleValid(sampleValid), .frameErr(frameErr)
  );
endmodule

// File: tb/sar_link_reader_tb.sv
module sar_link_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_ACQ    = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  divCfg = '0;
  logic [7:0]  gapCfg = '0;
  logic        sdoIn;
  logic        csN, sck, sampleValid, frameErr;
  logic [13:0] sampleData;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_link_reader #(.MIN_ACQ_CYC(MIN_ACQ)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .divCfg(divCfg), .gapCfg(gapCfg),
    .sdoIn(sdoIn), .csN(csN), .sck(sck), .sampleData(sampleData),
    .sampleValid(sampleValid), .frameErr(frameErr)
  );

  task automatic check(input bit ok, input string req, input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  // ---- behavioural converter: word of a frame is the previous conversion ----
  logic [15:0] curWord = '0;
  logic [13:0] prevConv = '0;
  int convCnt = 0;
  int bitK = 16;

  function automatic logic [13:0] convVal(input int n);
    if (n % 5 == 0) return 14'h3FFF;
    if (n % 5 == 1) return 14'h0000;
    return 14'((n * 1237 + 5) & 16'h3FFF);
  endfunction

  always @(negedge csN) begin
    curWord  = {(convCnt % 7 == 3), prevConv, (convCnt % 11 == 5)};
    prevConv = convVal(convCnt);
    convCnt++;
    bitK = 0;
  end
  always @(negedge sck) if (!csN) bitK++;
  assign sdoIn = (!csN && bitK < 16) ? curWord[15 - bitK] : 1'b0;

  // ---- monitor, sampled on the falling system clock ----
  int  cyc = 0;
  bit  prevCs = 1'b1, prevSck = 1'b0;
  bit  firstOfRun = 1'b1;
  int  runFrames = 0, validsRun = 0;
  int  rises = 0, lastRise = 0, csHigh = 0;
  int  expHalf = 1, expAcq = MIN_ACQ;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (prevCs && !csN) begin
        if (!firstOfRun) check(csHigh == expAcq, "R7 gap length", csHigh, expAcq);
        firstOfRun = 1'b0;
        runFrames++;
        rises = 0;
      end
      if (csN) csHigh = prevCs ? csHigh + 1 : 1;
      if (!prevSck && sck) begin
        rises++;
        if (rises > 1) check(cyc - lastRise == 2 * expHalf, "R6 sck period", cyc - lastRise, 2 * expHalf);
        lastRise = cyc;
        if (csN) check(1'b0, "R2 sck high with csN high", 1, 0);
      end
      if (!prevCs && csN) check(rises == 16, "R2 rises per frame", rises, 16);
      if (sampleValid) begin
        validsRun++;
        check(sampleData == curWord[14:1], "R3/R4 sample word", sampleData, curWord[14:1]);
        check(frameErr == (curWord[15] | curWord[0]), "R5 pad error", frameErr, curWord[15] | curWord[0]);
      end
    end
    prevCs  = csN;
    prevSck = sck;
  end

  task automatic runCfg(input int dv, input int gp, input int nFrames);
    int cnt0;
    @(negedge clk);
    divCfg = 8'(dv);
    gapCfg = 8'(gp);
    expHalf = dv + 1;
    expAcq = (2 * gp * (dv + 1) > MIN_ACQ) ? 2 * gp * (dv + 1) : MIN_ACQ;
    runFrames = 0;
    validsRun = 0;
    firstOfRun = 1'b1;
    enable = 1'b1;
    while (runFrames < nFrames) @(negedge clk);
    enable = 1'b0;             // R8: dropped mid-frame
    while (!csN) @(negedge clk);
    repeat (3) @(negedge clk);
    check(validsRun == nFrames - 1, "R4 valid count", validsRun, nFrames - 1);
    cnt0 = convCnt;
    repeat (40 + 4 * expAcq) @(negedge clk);
    check(csN == 1'b1 && convCnt == cnt0, "R8 idle after disable", convCnt, cnt0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(csN == 1'b1, "R1 csN in reset", csN, 1);
    check(sck == 1'b0, "R1 sck in reset", sck, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(csN == 1'b1 && sck == 1'b0 && sampleValid == 1'b0, "R1 after reset", sampleValid, 0);
    for (int d = 0; d < 4; d++) begin
      runCfg(d, 0, 5);
      runCfg(d, 1, 5);
      runCfg(d, 3, 6);
    end
    runCfg(0, 9, 4);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule